// File: doc/BRIEF.md
# Bus Mastership Handoff Controller

This block sits on the master side of a shared external memory bus. It lets an external device borrow the bus through a request/acknowledge handshake, and it hands the bus back to the local master when the request goes away. It produces output enables for three pad groups: address, data, and the control strobes. It also produces the acknowledge, a refresh-pending request that asks the holder to give the bus back, a pulse-level indication that a refresh may run, and an indication that local bus cycles may run.

The bus edges are double-sided. Some steps happen on the rising bus edge and some on the falling one, each half a bus cycle apart. The block runs from one clock at twice the bus rate. An internal phase bit marks each clock edge as either a rising or a falling bus edge, and the block outputs the regenerated bus clock. A grant starts only when the local sequencer is idle and no refresh is waiting. The release order is fixed: address and data float first, then the acknowledge goes up, then the strobes float. The reclaim runs in the reverse order.

Top module: `bus_handoff`

## Requirements
- R1: While reset is high and after it: all three enables are 1, `local_ok_o` is 1, `ack_o`, `refreq_o`, `refresh_go_o` and `bus_clk_o` are 0.
- R2: `breq_i` is looked at only on falling bus edges. A request that is high only across rising edges starts nothing.
- R3: On the first rising bus edge after a falling edge that saw `breq_i` high, `addr_oe_o` and `data_oe_o` go to 0, provided the sequencer is idle and no refresh is pending. `local_ok_o` drops at the same edge.
- R4: `ack_o` rises on the falling bus edge that follows the float of address and data.
- R5: The control strobes float (`ctrl_oe_o` = 0) on the next rising bus edge after `ack_o` rises, and never while `ack_o` is 0.
- R6: Once the bus is held, a falling edge that sees `breq_i` low is followed three clock edges (1.5 bus cycles) later, on a rising edge, by `ctrl_oe_o` = 1.
- R7: `ack_o` falls on the falling bus edge right after the strobes are driven again.
- R8: On the next rising bus edge, `addr_oe_o`, `data_oe_o` and `local_ok_o` return to 1.
- R9: While `seq_idle_i` is 0, no grant starts. It starts on the first rising edge with idle high, provided the request is still sampled high.
- R10: While `refresh_pend_i` is 1 and the master owns the bus, no grant starts and `refresh_go_o` is 1.
- R11: While the bus is released and `refresh_pend_i` is 1, `refreq_o` is 1. It clears on the edge where address and data are driven again, and at that edge `refresh_go_o` rises.
- R12: A request dropped before the grant has finished still completes the grant. The first falling edge in the held state then starts the reclaim.
- R13: `bus_clk_o` is 1 after a rising bus edge and 0 after a falling one. The first clock edge after reset is a rising bus edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| breq_i | input | 1 | External bus request, active high |
| refresh_pend_i | input | 1 | SDRAM refresh waiting, from the refresh timer |
| seq_idle_i | input | 1 | Local bus sequencer is idle |
| addr_oe_o | output | 1 | Address pad drive enable |
| data_oe_o | output | 1 | Data pad drive enable |
| ctrl_oe_o | output | 1 | Control strobe drive enable (driven inactive high when 1) |
| ack_o | output | 1 | Bus acknowledge to the external device |
| refreq_o | output | 1 | Asks the external holder to return the bus for a refresh |
| refresh_go_o | output | 1 | Refresh may run now (bus owned, refresh pending) |
| local_ok_o | output | 1 | Local bus cycles may run |
| bus_clk_o | output | 1 | Regenerated bus clock |

## Verification
A wrong state shows at the ports within one clock edge, because every output is a registered decode of the next state. A skipped or repeated step moves the rise or fall of one enable or of the acknowledge by one or more edges. A phase error moves every transition by exactly one clock and also flips `bus_clk_o`. The bench sweeps the hold length, the idle and refresh blockers, and a refresh raised while the bus is held. For each of these it predicts every output on every edge from the index of the falling edge that first sees the request.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic [3:0] {
    ST_OWN    = 4'd0,
    ST_FLOAT  = 4'd1,
    ST_ACK    = 4'd2,
    ST_HELD   = 4'd3,
    ST_REL_A  = 4'd4,
    ST_REL_B  = 4'd5,
    ST_REL_C  = 4'd6,
    ST_DRV    = 4'd7,
    ST_ACKOFF = 4'd8
  } hand_st_t;
endpackage

// File: rtl/bh_phase.sv
module bh_phase (
  input  logic clk,
  input  logic rst,
  output logic is_rise,
  output logic bus_clk_o
);
  logic ph_q;

  assign is_rise = ~ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= 1'b0;
      bus_clk_o <= 1'b0;
    end else begin
      ph_q      <= ~ph_q;
      bus_clk_o <= is_rise;
    end
  end

  p_phase_alt_r13: assert property (@(posedge clk) disable iff (rst)
    $past(bus_clk_o) != bus_clk_o || $past(rst));
endmodule

// File: rtl/bh_req_sample.sv
module bh_req_sample (
  input  logic clk,
  input  logic rst,
  input  logic is_rise,
  input  logic breq_i,
  output logic req_s
);
  always_ff @(posedge clk) begin
    if (rst)           req_s <= 1'b0;
    else if (!is_rise) req_s <= breq_i;
  end

  p_sample_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $past(is_rise) |-> $stable(req_s));
endmodule

// File: rtl/bh_fsm.sv
module bh_fsm
  import bh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic is_rise,
  input  logic req_s,
  input  logic breq_i,
  input  logic seq_idle_i,
  input  logic refresh_pend_i,
  output logic own_n,
  output logic addr_oe_q,
  output logic data_oe_q,
  output logic ctrl_oe_q,
  output logic ack_q,
  output logic local_ok_q
);
  hand_st_t st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_OWN:    if (is_rise && req_s && seq_idle_i && !refresh_pend_i) st_n = ST_FLOAT;
      ST_FLOAT:  if (!is_rise) st_n = ST_ACK;
      ST_ACK:    if (is_rise)  st_n = ST_HELD;
      ST_HELD:   if (!is_rise && !breq_i) st_n = ST_REL_A;
      ST_REL_A:  if (is_rise)  st_n = ST_REL_B;
      ST_REL_B:  if (!is_rise) st_n = ST_REL_C;
      ST_REL_C:  if (is_rise)  st_n = ST_DRV;
      ST_DRV:    if (!is_rise) st_n = ST_ACKOFF;
      ST_ACKOFF: if (is_rise)  st_n = ST_OWN;
      default:   st_n = ST_OWN;
    endcase
  end

  assign own_n = (st_n == ST_OWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_OWN;
      addr_oe_q  <= 1'b1;
      data_oe_q  <= 1'b1;
      ctrl_oe_q  <= 1'b1;
      ack_q      <= 1'b0;
      local_ok_q <= 1'b1;
    end else begin
      st_q       <= st_n;
      addr_oe_q  <= own_n;
      data_oe_q  <= own_n;
      local_ok_q <= own_n;
      ctrl_oe_q  <= !(st_n inside {ST_HELD, ST_REL_A, ST_REL_B, ST_REL_C});
      ack_q      <= st_n inside {ST_ACK, ST_HELD, ST_REL_A, ST_REL_B, ST_REL_C, ST_DRV};
    end
  end

  p_float_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(addr_oe_q) |-> $past(is_rise));
  p_ack_after_float_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> (!addr_oe_q && $past(!addr_oe_q) && $past(!is_rise)));
  p_strobes_need_ack_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_oe_q |-> ack_q);
  p_redrive_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_oe_q) |-> $past(is_rise));
  p_ack_drop_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_q) |-> (ctrl_oe_q && $past(ctrl_oe_q) && $past(!is_rise)));
  p_ad_return_last_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_oe_q) |-> (ctrl_oe_q && !ack_q && $past(!ack_q)));
  p_ad_pair_r3: assert property (@(posedge clk) disable iff (rst)
    addr_oe_q == data_oe_q);
endmodule

// File: rtl/bh_refresh.sv
module bh_refresh (
  input  logic clk,
  input  logic rst,
  input  logic refresh_pend_i,
  input  logic own_n,
  output logic refreq_q,
  output logic refresh_go_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      refreq_q     <= 1'b0;
      refresh_go_q <= 1'b0;
    end else begin
      refreq_q     <= refresh_pend_i && !own_n;
      refresh_go_q <= refresh_pend_i && own_n;
    end
  end

  p_req_go_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(refreq_q && refresh_go_q));
endmodule

// File: rtl/bus_handoff.sv
module bus_handoff (
  input  logic clk,
  input  logic rst,
  input  logic breq_i,
  input  logic refresh_pend_i,
  input  logic seq_idle_i,
  output logic addr_oe_o,
  output logic data_oe_o,
  output logic ctrl_oe_o,
  output logic ack_o,
  output logic refreq_o,
  output logic refresh_go_o,
  output logic local_ok_o,
  output logic bus_clk_o
);
  logic is_rise;
  logic req_s;
  logic own_n;

  bh_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .is_rise   (is_rise),
    .bus_clk_o (bus_clk_o)
  );

  bh_req_sample u_sample (
    .clk     (clk),
    .rst     (rst),
    .is_rise (is_rise),
    .breq_i  (breq_i),
    .req_s   (req_s)
  );

  bh_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .is_rise        (is_rise),
    .req_s          (req_s),
    .breq_i         (breq_i),
    .seq_idle_i     (seq_idle_i),
    .refresh_pend_i (refresh_pend_i),
    .own_n          (own_n),
    .addr_oe_q      (addr_oe_o),
    .data_oe_q      (data_oe_o),
    .ctrl_oe_q      (ctrl_oe_o),
    .ack_q          (ack_o),
    .local_ok_q     (local_ok_o)
  );

  bh_refresh u_refresh (
    .clk            (clk),
    .rst            (rst),
    .refresh_pend_i (refresh_pend_i),
    .own_n          (own_n),
    .refreq_q       (refreq_o),
    .refresh_go_q   (refresh_go_o)
  );

  p_refreq_when_released_r11: assert property (@(posedge clk) disable iff (rst)
    refreq_o |-> !addr_oe_o);
  p_go_when_owned_r10: assert property (@(posedge clk) disable iff (rst)
    refresh_go_o |-> (addr_oe_o && local_ok_o));
endmodule

// File: tb/sim_bus_handoff.sv
`timescale 1ns/1ps
module sim_bus_handoff;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic breq = 1'b0, pend = 1'b0, idle = 1'b1;
  logic addr_oe, data_oe, ctrl_oe, ack, refreq, refgo, lok, bclk;
  int tests = 0, fails = 0, e = -1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_handoff u0 (
    .clk(clk), .rst(rst), .breq_i(breq), .refresh_pend_i(pend), .seq_idle_i(idle),
    .addr_oe_o(addr_oe), .data_oe_o(data_oe), .ctrl_oe_o(ctrl_oe), .ack_o(ack),
    .refreq_o(refreq), .refresh_go_o(refgo), .local_ok_o(lok), .bus_clk_o(bclk)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s edge %0d: got %b expected %b", tag, what, e, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    e++;
    @(negedge clk);
  endtask

  task automatic chk_idle_bus(string tag);
    chk(tag, "addr_oe", addr_oe, 1'b1);
    chk(tag, "data_oe", data_oe, 1'b1);
    chk(tag, "ctrl_oe", ctrl_oe, 1'b1);
    chk(tag, "ack", ack, 1'b0);
    chk(tag, "local_ok", lok, 1'b1);
    chk("R13", "bus_clk", bclk, (e % 2 == 0));
  endtask

  // blocker: 0 none, 1 idle low (R9), 2 refresh pending (R10)
  task automatic scenario(int blocker, int w, int h, bit rm);
    int k0, g, j, drop;
    string btag, tag;
    logic p, inrel;
    breq = 1'b0; pend = 1'b0; idle = 1'b1;
    if (e % 2 != 0) begin
      adv();
      chk_idle_bus("R8");
    end
    k0   = e + 1;
    g    = k0 + 1 + 2 * w;
    j    = g + 1 + 2 * ((h < 1) ? 1 : h);
    drop = g + 1 + 2 * h;
    btag = (blocker == 1) ? "R9" : "R10";
    for (int ee = k0; ee <= j + 6; ee++) begin
      breq = (ee < drop);
      idle = (blocker != 1) || (ee >= g);
      p    = ((blocker == 2) && (ee < g)) || (rm && (ee >= g + 3) && (ee <= j + 5));
      pend = p;
      adv();
      inrel = (ee >= g) && (ee <= j + 4);
      tag = (ee < g && blocker != 0) ? btag : (h == 0) ? "R12" : (ee <= j) ? "R3" : "R8";
      chk(tag, "addr_oe", addr_oe, !inrel);
      chk(tag, "data_oe", data_oe, !inrel);
      chk((ee < g && blocker != 0) ? btag : "R8", "local_ok", lok, !inrel);
      chk((ee <= j) ? "R4" : "R7", "ack", ack, (ee >= g + 1) && (ee <= j + 3));
      chk((ee <= j) ? "R5" : "R6", "ctrl_oe", ctrl_oe, !((ee >= g + 2) && (ee <= j + 2)));
      chk("R11", "refreq", refreq, p && inrel);
      chk((blocker == 2 && ee < g) ? "R10" : "R11", "refresh_go", refgo, p && !inrel);
      chk("R13", "bus_clk", bclk, (ee % 2 == 0));
    end
    breq = 1'b0; pend = 1'b0; idle = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values while reset is held
    chk("R1", "addr_oe", addr_oe, 1'b1);
    chk("R1", "data_oe", data_oe, 1'b1);
    chk("R1", "ctrl_oe", ctrl_oe, 1'b1);
    chk("R1", "ack", ack, 1'b0);
    chk("R1", "refreq", refreq, 1'b0);
    chk("R1", "refresh_go", refgo, 1'b0);
    chk("R1", "local_ok", lok, 1'b1);
    chk("R1", "bus_clk", bclk, 1'b0);
    rst = 1'b0;
    adv();
    chk_idle_bus("R1");
    chk("R1", "refreq", refreq, 1'b0);
    // R2: request present only across rising edges is ignored
    for (int n = 0; n < 8; n++) begin
      breq = ((e + 1) % 2 == 0);
      adv();
      chk_idle_bus("R2");
    end
    breq = 1'b0;
    adv();
    chk_idle_bus("R2");
    adv();
    chk_idle_bus("R2");
    for (int b = 0; b < 3; b++)
      for (int w = (b == 0) ? 0 : 1; w <= ((b == 0) ? 0 : 2); w++)
        for (int h = 0; h < 5; h++)
          for (int r = 0; r < 2; r++)
            scenario(b, w, h, r[0]);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule